// File: doc/BRIEF.md
# Per-Region Bus Wait-State Controller

This block times accesses on an external memory bus with a 24-bit byte address. It splits the address space into eight equal regions. Each region has its own setting for a short two-cycle access or a longer three-cycle access. A three-cycle region can also be given extra wait cycles. A single global wait count, written through a small configuration write port, sets how many wait cycles are added.

A bus master raises `req` with an address while the controller is idle. The controller then drives `busy` for the whole access and `strobe` from the second busy cycle onward. It pulses `done` in the final busy cycle. The region settings are captured when the request is accepted, so a configuration write during an access changes only later accesses. After every access the bus is idle for exactly one cycle, and a request held in that cycle starts the next access.

Top module: `wait_state_ctrl`

## Requirements
- R1: The region of an access is taken from the top three address bits, `addr[23:21]`. The lower 21 bits have no influence on timing.
- R2: An access to a region whose mode bit is 0 (two-state) keeps `busy` high for exactly 2 cycles.
- R3: An access to a region whose mode bit is 1 (three-state) and whose wait-enable bit is 0 keeps `busy` high for exactly 3 cycles.
- R4: An access to a three-state region whose wait-enable bit is 1 keeps `busy` high for 3 + W cycles, where W is the 2-bit wait count.
- R5: The wait-enable bit has no effect on a two-state region, which still takes 2 cycles.
- R6: While `rst_n` is low, `busy`, `strobe` and `done` are 0. After reset every mode bit and every wait-enable bit is 1 and W is 3, so every access takes 6 cycles.
- R7: `strobe` is low in the first busy cycle of an access and high in every later busy cycle of it.
- R8: `done` is high only in the last busy cycle of an access, for exactly one cycle. `busy` is low in the following cycle.
- R9: A request is sampled only while `busy` is low. A request held through an access is ignored until the idle cycle after `done`, and is accepted in that idle cycle.
- R10: A configuration write takes effect at the clock edge on which `cfg_we` is high. The value of `cfg_sel` chooses the target:
  - 0 writes the mode bits, with bit r for region r.
  - 1 writes the wait-enable bits, with bit r for region r.
  - 2 writes W from `cfg_wdata[1:0]`.
  - 3 changes nothing.
- R11: The timing of an access is fixed by the settings in force at the edge where it is accepted. Writes made during the access do not change its length.
- R12: With wait-enable set on a three-state region and W equal to 0, the access takes 3 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Access request, sampled while idle |
| addr | input | 24 | Byte address of the request |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 2 | Configuration target: 0 mode, 1 wait-enable, 2 wait count, 3 none |
| cfg_wdata | input | 8 | Configuration write data |
| busy | output | 1 | Access in progress |
| strobe | output | 1 | Data strobe, high from the second busy cycle onward |
| done | output | 1 | One-cycle pulse in the final busy cycle |

## Verification
The bench builds the block with its default parameters: a 24-bit address, eight regions and a 2-bit wait count. These values make the full range of access lengths reachable, from 2 cycles up to the 6-cycle reset default. They also allow every region boundary to be probed with real addresses on both sides, and allow W to be stepped through 0, 1, 2 and 3. Further tests cover a request held across a whole access, configuration writes made during an access, and writes to the unused target code.

// File: rtl/wsc_pkg.sv
// Package wsc_pkg
// Shared encodings for the wait-state controller.
// Assumes a 2-bit configuration select.
package wsc_pkg;
    typedef enum logic [1:0] {
        CFG_MODE  = 2'd0,
        CFG_WEN   = 2'd1,
        CFG_WCNT  = 2'd2,
        CFG_NONE  = 2'd3
    } cfg_sel_e;
endpackage

// File: rtl/wsc_cfg_regs.sv
// Module wsc_cfg_regs
// Holds the per-region mode mask, the per-region wait-enable mask and
// the global wait count. Writes only; nothing is read back.
// Assumes REGIONS >= WAIT_W, so the wait count fits in the write data.
module wsc_cfg_regs
    import wsc_pkg::*;
#(
    parameter int REGIONS = 8,
    parameter int WAIT_W  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [1:0]         sel,
    input  logic [REGIONS-1:0] wdata,
    output logic [REGIONS-1:0] mode_q,
    output logic [REGIONS-1:0] wen_q,
    output logic [WAIT_W-1:0]  wcnt_q
);
    // Apply register writes; reset selects the slowest timing everywhere.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '1;
            wen_q  <= '1;
            wcnt_q <= '1;
        end else if (we) begin
            case (cfg_sel_e'(sel))
                CFG_MODE: mode_q <= wdata;
                CFG_WEN:  wen_q  <= wdata;
                CFG_WCNT: wcnt_q <= wdata[WAIT_W-1:0];
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/wsc_len_calc.sv
// Module wsc_len_calc
// Computes the access length in cycles for every region, then picks
// the one for the requested region. Pure combinational logic.
// Assumes LEN_W is wide enough to hold 3 + (2**WAIT_W - 1).
module wsc_len_calc #(
    parameter int REGIONS = 8,
    parameter int WAIT_W  = 2,
    parameter int RGN_W   = 3,
    parameter int LEN_W   = 4
) (
    input  logic [REGIONS-1:0] mode,
    input  logic [REGIONS-1:0] wen,
    input  logic [WAIT_W-1:0]  wcnt,
    input  logic [RGN_W-1:0]   region,
    output logic [LEN_W-1:0]   len
);
    logic [LEN_W-1:0] len_tab [REGIONS];

    for (genvar r = 0; r < REGIONS; r++) begin : g_rgn
        // Length of an access to region r under the current settings.
        always_comb begin
            if (mode[r])
                len_tab[r] = LEN_W'(3) + (wen[r] ? LEN_W'(wcnt) : '0);
            else
                len_tab[r] = LEN_W'(2);
        end
    end

    // Select the entry of the addressed region.
    always_comb len = len_tab[region];
endmodule

// File: rtl/wsc_seq.sv
// Module wsc_seq
// Access sequencer. It accepts a request only while idle, then counts
// down the captured length. It drives busy for the whole access, strobe
// from the second cycle on, and done in the last cycle.
// Assumes len >= 2 at acceptance.
module wsc_seq #(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [LEN_W-1:0] len,
    output logic             busy,
    output logic             strobe,
    output logic             done
);
    logic             busy_q;
    logic             first_q;
    logic [LEN_W-1:0] rem_q;

    // Start, count down and finish an access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            first_q <= 1'b0;
            rem_q   <= '0;
        end else if (!busy_q) begin
            if (req) begin
                busy_q  <= 1'b1;
                first_q <= 1'b1;
                rem_q   <= len - LEN_W'(1);
            end
        end else begin
            first_q <= 1'b0;
            if (rem_q == '0)
                busy_q <= 1'b0;
            else
                rem_q <= rem_q - LEN_W'(1);
        end
    end

    // Output decode from the sequencer state.
    always_comb begin
        busy   = busy_q;
        strobe = busy_q && !first_q;
        done   = busy_q && (rem_q == '0);
    end
endmodule

// File: rtl/wait_state_ctrl.sv
// Module wait_state_ctrl
// Top level of the per-region wait-state controller. The region is taken
// from the upper address bits. Each region uses a two-state or a
// three-state access, and optional wait cycles extend a three-state one.
// Assumes REGIONS is a power of two.
module wait_state_ctrl #(
    parameter int ADDR_W  = 24,
    parameter int REGIONS = 8,
    parameter int WAIT_W  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_sel,
    input  logic [REGIONS-1:0] cfg_wdata,
    output logic               busy,
    output logic               strobe,
    output logic               done
);
    localparam int RGN_W = $clog2(REGIONS);
    localparam int LEN_W = WAIT_W + 2;

    logic [REGIONS-1:0] mode_q;
    logic [REGIONS-1:0] wen_q;
    logic [WAIT_W-1:0]  wcnt_q;
    logic [RGN_W-1:0]   region;
    logic [LEN_W-1:0]   acc_len;
    logic               unused_addr_bits;

    // Region select from the top address bits.
    always_comb region = addr[ADDR_W-1 -: RGN_W];
    always_comb unused_addr_bits = ^addr[ADDR_W-RGN_W-1:0];

    wsc_cfg_regs #(.REGIONS(REGIONS), .WAIT_W(WAIT_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .sel    (cfg_sel),
        .wdata  (cfg_wdata),
        .mode_q (mode_q),
        .wen_q  (wen_q),
        .wcnt_q (wcnt_q)
    );

    wsc_len_calc #(.REGIONS(REGIONS), .WAIT_W(WAIT_W), .RGN_W(RGN_W), .LEN_W(LEN_W)) u_len (
        .mode   (mode_q),
        .wen    (wen_q),
        .wcnt   (wcnt_q),
        .region (region),
        .len    (acc_len)
    );

    wsc_seq #(.LEN_W(LEN_W)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (req),
        .len    (acc_len),
        .busy   (busy),
        .strobe (strobe),
        .done   (done)
    );
endmodule

// File: rtl/wsc_checker.sv
// Module wsc_checker
// Temporal checks on the controller ports and its captured mode mask.
// Attached to every wait_state_ctrl instance by the bind below.
module wsc_checker #(
    parameter int REGIONS = 8,
    parameter int RGN_W   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req,
    input logic               busy,
    input logic               strobe,
    input logic               done,
    input logic [REGIONS-1:0] mode_q,
    input logic [RGN_W-1:0]   region
);
    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (!busy && !strobe && !done)); // R6

    AST_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !busy) |=> busy); // R9

    AST_TWO_STATE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !busy && !mode_q[region]) |=> !done ##1 done); // R2

    AST_THREE_STATE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !busy && mode_q[region]) |=> !done ##1 !done); // R3

    AST_STROBE_FIRST_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !busy) |=> !strobe); // R7

    AST_STROBE_LATER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> strobe); // R7

    AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy); // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy)); // R8
endmodule

bind wait_state_ctrl wsc_checker #(.REGIONS(REGIONS), .RGN_W(RGN_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (req),
    .busy   (busy),
    .strobe (strobe),
    .done   (done),
    .mode_q (mode_q),
    .region (region)
);

// File: tb/sim_wait_state_ctrl.sv
// Bench sim_wait_state_ctrl
// Scoreboard bench. Driver tasks push the expected access length and a
// requirement tag into queues. A monitor measures every access at the
// falling edge and compares its measurements with the queued items.
module sim_wait_state_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [23:0] addr = '0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        busy, strobe, done;

    int errors = 0;
    int checks = 0;
    int    exp_q [$];
    string tag_q [$];

    always #10 clk = ~clk;

    wait_state_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .addr(addr),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .busy(busy), .strobe(strobe), .done(done)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: measure busy length, strobe count and first-cycle strobe.
    int  mon_len = 0;
    int  mon_stb = 0;
    bit  prev_done = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_done) check(!busy, "R8 idle after done", busy, 0);
            if (busy) begin
                mon_len++;
                if (strobe) mon_stb++;
                if (mon_len == 1 && strobe) check(0, "R7 strobe in first cycle", 1, 0);
            end
            if (done) begin
                if (exp_q.size() == 0) begin
                    check(0, "R9 unexpected access", 1, 0);
                end else begin
                    int    e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(mon_len == e, {t, " length"}, mon_len, e);
                    check(mon_stb == e - 1, "R7 strobe count", mon_stb, e - 1);
                end
                mon_len = 0;
                mon_stb = 0;
            end
            prev_done = done;
        end
    end

    task automatic wait_done();
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic access(input logic [23:0] a, input int len, input string tag);
        exp_q.push_back(len);
        tag_q.push_back(tag);
        addr = a;
        req  = 1'b1;
        @(negedge clk);
        req  = 1'b0;
        wait_done();
    endtask

    task automatic cfg_write(input logic [1:0] s, input logic [7:0] d);
        cfg_sel   = s;
        cfg_wdata = d;
        cfg_we    = 1'b1;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !strobe && !done, "R6 outputs in reset", {busy, strobe, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6 reset defaults: three-state, waits on, W=3
        access(24'h00_0000, 6, "R6 region0 default");
        access(24'hFF_FFFF, 6, "R6 region7 default");

        // R4 wait count 1
        cfg_write(2'd2, 8'h01);
        access(24'h40_0123, 4, "R4 W=1");
        // R3 waits disabled
        cfg_write(2'd1, 8'h00);
        access(24'h40_0000, 3, "R3 no waits");
        // R12 waits enabled, W=0
        cfg_write(2'd1, 8'hFF);
        cfg_write(2'd2, 8'h00);
        access(24'h40_0000, 3, "R12 W=0");

        // R2 R5 R1: region 5 two-state with waits still enabled, W=2
        cfg_write(2'd2, 8'h02);
        cfg_write(2'd0, 8'b1101_1111);
        access(24'hA0_0000, 2, "R2 R5 two-state with waits on");
        access(24'hBF_FFFF, 2, "R1 top of region5");
        access(24'h9F_FFFF, 5, "R1 top of region4");
        access(24'hC0_0000, 5, "R1 bottom of region6");

        // R10 select 3 writes nothing
        cfg_write(2'd3, 8'h00);
        access(24'hA0_0000, 2, "R10 sel3 keeps mode");
        access(24'h80_0000, 5, "R10 sel3 keeps W");

        // R11 writes during an access do not change it
        exp_q.push_back(5);
        tag_q.push_back("R11 mid-access write");
        addr = 24'h80_0000;
        req  = 1'b1;
        @(negedge clk);
        req  = 1'b0;
        cfg_write(2'd0, 8'hFF);
        cfg_write(2'd2, 8'h00);
        wait_done();
        access(24'hA0_0000, 3, "R11 new settings apply next");

        // R9 request held across the access: one idle cycle, then a restart
        exp_q.push_back(3);
        tag_q.push_back("R9 first held access");
        exp_q.push_back(3);
        tag_q.push_back("R9 second held access");
        addr = 24'h00_0000;
        req  = 1'b1;
        @(negedge clk);
        while (!done) @(negedge clk);
        @(negedge clk);
        check(!busy, "R9 idle cycle after done", busy, 0);
        @(negedge clk);
        check(busy, "R9 accepted in cycle after done", busy, 1);
        req = 1'b0;
        wait_done();

        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R9 all accesses seen", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule